// File: doc/BRIEF.md
# Strobed Output Compare Unit

This block judges the outputs of a device under functional test, once per tester cycle and separately for every pin. Each pin has three inputs. The first is a two-bit expected code: low, high or don't-care. The other two are digitised comparator flags: one says the pin voltage is at or above the high threshold, the other says it is at or below the low threshold. A tester cycle lasts `PHASES` clocks. A programmable strobe picks which of those clocks count. In edge mode a single phase is sampled. In window mode every phase of a contiguous range is sampled, and one bad sample in the range is enough to fail the pin.

A small state machine has two states, `ST_IDLE` and `ST_RUN`. The transition `IDLE->RUN` is taken on `pat_start`. The transition `RUN->RUN` (restart) is also taken on `pat_start`. The transition `RUN->IDLE` (abort) is taken on `pat_end`. If both pulses arrive together, `pat_start` wins. At the close of each tester cycle the block reports a per-pin fail vector. It also keeps a sticky functional-fail flag, the index of the first failing cycle, and the pin mask of that cycle. All three are held until the next `pat_start`.

Top module: `strobe_compare`

## Requirements
- R1: A pin whose expected code is `2'b01` (high) passes a sample only when its `above_vh` flag is 1.
- R2: A pin whose expected code is `2'b00` (low) passes a sample only when its `below_vl` flag is 1.
- R3: A sample with both flags at 0 (the band between the thresholds) fails for either expected level.
- R4: An expected code with bit 1 set (`2'b10` or `2'b11`) masks the pin for that cycle, so it never fails.
- R5: With `win_mode`=0 only phase `strb_pos` is judged; values in every other phase have no effect.
- R6: With `win_mode`=1 every phase from `strb_pos` to `strb_pos+strb_len` inclusive is judged, and a single bad sample fails the pin. Phases outside that range have no effect.
- R7: Phases run from 0 to `PHASES-1`, starting with the first clock after `pat_start`. One clock after phase `PHASES-1`, `cyc_done` pulses for one clock and `pin_fail` holds that cycle's per-pin result (bit i is pin i).
- R8: `func_fail` rises together with any `cyc_done` whose `pin_fail` is non-zero. It then stays at 1 until `pat_start`, including through `pat_end`.
- R9: `first_cyc` and `first_mask` capture the cycle index (0 is the first cycle after `pat_start`) and the `pin_fail` value of the first failing cycle. Later failures do not change them.
- R10: `pat_start` clears `func_fail`, `first_cyc`, `first_mask` and the cycle index, and enters `ST_RUN`. `busy` is 1 in `ST_RUN`.
- R11: `pat_end` returns to `ST_IDLE` one clock later. The partial cycle produces no `cyc_done`.
- R12: After reset, `busy`, `cyc_done`, `pin_fail`, `func_fail`, `first_cyc` and `first_mask` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per strobe phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| pat_start | input | 1 | Start or restart a pattern; clears the fail record |
| pat_end | input | 1 | Abort or end the pattern |
| win_mode | input | 1 | 0 selects edge strobe, 1 selects window strobe |
| strb_pos | input | PW | Strobe phase, or first phase of the window |
| strb_len | input | PW | Number of extra window phases after `strb_pos` |
| exp_code | input | 2*N_PINS | Expected code per pin, bits [2i+1:2i] |
| above_vh | input | N_PINS | Per-pin flag: output at or above the high threshold |
| below_vl | input | N_PINS | Per-pin flag: output at or below the low threshold |
| busy | output | 1 | State machine is in `ST_RUN` |
| cyc_done | output | 1 | One-clock pulse at the close of each tester cycle |
| pin_fail | output | N_PINS | Per-pin fail result, valid with `cyc_done` |
| func_fail | output | 1 | Sticky functional fail |
| first_cyc | output | CYC_W | Index of the first failing cycle |
| first_mask | output | N_PINS | Pin fail vector of the first failing cycle |

## Verification
The bench uses the default parameters: four pins, eight phases per tester cycle, and a 16-bit cycle index. Eight phases give room for a strobe at the first phase and at the last phase. They also allow a window with phases both before and after it, so a disturbance can be placed inside the window, at its last phase, or just past it. Four pins allow one vector to mix expected-high, expected-low and don't-care pins, and to show that a failure on one pin leaves its neighbours passing.

// File: rtl/scu_pkg.sv
package scu_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } scu_state_e;

    // Expected code per pin: 00 low, 01 high, 1x masked.
    localparam logic [1:0] EXP_LOW  = 2'b00;
    localparam logic [1:0] EXP_HIGH = 2'b01;

    function automatic logic sample_bad(input logic [1:0] code,
                                        input logic above,
                                        input logic below);
        if (code[1])
            return 1'b0;
        else if (code == EXP_HIGH)
            return !above;
        else
            return !below;
    endfunction

endpackage

// File: rtl/scu_phase_gen.sv
module scu_phase_gen #(
    parameter int PHASES = 8,
    parameter int PW     = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          restart,
    input  logic          win_mode,
    input  logic [PW-1:0] strb_pos,
    input  logic [PW-1:0] strb_len,
    output logic [PW-1:0] phase,
    output logic          last,
    output logic          strobe_en
);

    localparam logic [PW-1:0] LAST_PH = PW'(PHASES - 1);

    logic [PW:0] win_lo;
    logic [PW:0] win_hi;
    logic [PW:0] ph_ext;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase <= '0;
        else if (!run || restart || phase == LAST_PH)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    always_comb begin
        win_lo    = {1'b0, strb_pos};
        win_hi    = win_lo + {1'b0, strb_len};
        ph_ext    = {1'b0, phase};
        last      = run && (phase == LAST_PH);
        if (win_mode)
            strobe_en = run && (ph_ext >= win_lo) && (ph_ext <= win_hi);
        else
            strobe_en = run && (phase == strb_pos);
    end

endmodule

// File: rtl/scu_pin_judge.sv
module scu_pin_judge #(
    parameter int N_PINS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                sample,
    input  logic [2*N_PINS-1:0] exp_code,
    input  logic [N_PINS-1:0]   above_vh,
    input  logic [N_PINS-1:0]   below_vl,
    output logic [N_PINS-1:0]   cyc_bad
);

    import scu_pkg::*;

    logic [N_PINS-1:0] acc;
    logic [N_PINS-1:0] bad_now;

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        assign bad_now[i] = sample &&
            sample_bad(exp_code[2*i +: 2], above_vh[i], below_vl[i]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                acc[i] <= 1'b0;
            else if (clear)
                acc[i] <= 1'b0;
            else if (bad_now[i])
                acc[i] <= 1'b1;
        end

        assign cyc_bad[i] = acc[i] | bad_now[i];
    end

endmodule

// File: rtl/scu_fail_log.sv
module scu_fail_log #(
    parameter int N_PINS = 4,
    parameter int CYC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              close,
    input  logic [N_PINS-1:0] cyc_bad,
    output logic              func_fail,
    output logic [CYC_W-1:0]  first_cyc,
    output logic [N_PINS-1:0] first_mask
);

    logic [CYC_W-1:0] cyc_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_idx    <= '0;
            func_fail  <= 1'b0;
            first_cyc  <= '0;
            first_mask <= '0;
        end else if (restart) begin
            cyc_idx    <= '0;
            func_fail  <= 1'b0;
            first_cyc  <= '0;
            first_mask <= '0;
        end else if (close) begin
            cyc_idx <= cyc_idx + 1'b1;
            if (|cyc_bad && !func_fail) begin
                func_fail  <= 1'b1;
                first_cyc  <= cyc_idx;
                first_mask <= cyc_bad;
            end
        end
    end

endmodule

// File: rtl/strobe_compare.sv
module strobe_compare #(
    parameter int N_PINS = 4,
    parameter int PHASES = 8,
    parameter int CYC_W  = 16,
    localparam int PW    = (PHASES > 2) ? $clog2(PHASES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pat_start,
    input  logic                pat_end,
    input  logic                win_mode,
    input  logic [PW-1:0]       strb_pos,
    input  logic [PW-1:0]       strb_len,
    input  logic [2*N_PINS-1:0] exp_code,
    input  logic [N_PINS-1:0]   above_vh,
    input  logic [N_PINS-1:0]   below_vl,
    output logic                busy,
    output logic                cyc_done,
    output logic [N_PINS-1:0]   pin_fail,
    output logic                func_fail,
    output logic [CYC_W-1:0]    first_cyc,
    output logic [N_PINS-1:0]   first_mask
);

    import scu_pkg::*;

    scu_state_e        state_q;
    scu_state_e        state_d;
    logic              run;
    logic              last;
    logic              strobe_en;
    logic              close;
    logic [PW-1:0]     phase;
    logic [N_PINS-1:0] cyc_bad;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (pat_start) state_d = ST_RUN;
            ST_RUN: begin
                if (pat_start)    state_d = ST_RUN;
                else if (pat_end) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign run   = (state_q == ST_RUN);
    assign busy  = run;
    assign close = last && !pat_start && !pat_end;

    scu_phase_gen #(.PHASES(PHASES), .PW(PW)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .restart   (pat_start),
        .win_mode  (win_mode),
        .strb_pos  (strb_pos),
        .strb_len  (strb_len),
        .phase     (phase),
        .last      (last),
        .strobe_en (strobe_en)
    );

    scu_pin_judge #(.N_PINS(N_PINS)) u_judge (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!run || pat_start || last),
        .sample   (strobe_en),
        .exp_code (exp_code),
        .above_vh (above_vh),
        .below_vl (below_vl),
        .cyc_bad  (cyc_bad)
    );

    scu_fail_log #(.N_PINS(N_PINS), .CYC_W(CYC_W)) u_log (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (pat_start),
        .close      (close),
        .cyc_bad    (cyc_bad),
        .func_fail  (func_fail),
        .first_cyc  (first_cyc),
        .first_mask (first_mask)
    );

    // Output process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_done <= 1'b0;
            pin_fail <= '0;
        end else begin
            cyc_done <= close;
            pin_fail <= close ? cyc_bad : '0;
        end
    end

endmodule

// File: rtl/strobe_compare_chk.sv
module strobe_compare_chk #(
    parameter int N_PINS = 4,
    parameter int CYC_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pat_start,
    input logic              pat_end,
    input logic              busy,
    input logic              cyc_done,
    input logic [N_PINS-1:0] pin_fail,
    input logic              func_fail,
    input logic [CYC_W-1:0]  first_cyc,
    input logic [N_PINS-1:0] first_mask
);

    p_done_needs_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |-> $past(busy));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> !cyc_done);

    p_fail_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && |pin_fail) |-> func_fail);

    p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (func_fail && !pat_start) |=> func_fail);

    p_first_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (func_fail && !pat_start) |=> ($stable(first_cyc) && $stable(first_mask)));

    p_mask_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        func_fail |-> (first_mask != '0));

    p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pat_start |=> (!func_fail && busy && first_mask == '0));

    p_end_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_end && !pat_start) |=> !busy);

endmodule

bind strobe_compare strobe_compare_chk #(.N_PINS(N_PINS), .CYC_W(CYC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pat_start  (pat_start),
    .pat_end    (pat_end),
    .busy       (busy),
    .cyc_done   (cyc_done),
    .pin_fail   (pin_fail),
    .func_fail  (func_fail),
    .first_cyc  (first_cyc),
    .first_mask (first_mask)
);

// File: tb/sim_strobe_compare.sv
`timescale 1ns/1ps
module sim_strobe_compare;

    localparam int N = 4;
    localparam int P = 8;
    localparam int CW = 16;
    localparam int NV = 11;

    typedef struct packed {
        logic [7:0] exp;
        logic       win;
        logic [2:0] pos;
        logic [2:0] len;
        logic [3:0] ab;
        logic [3:0] bl;
        logic [3:0] gph;
        logic [3:0] abg;
        logic [3:0] blg;
        logic [3:0] fail;
    } vec_t;

    // exp, win, pos, len, above, below, glitch phase (15 = none), glitch above, glitch below, expected fail
    localparam vec_t TBL [NV] = '{
        '{8'h00, 1'b0, 3'd3, 3'd0, 4'h0, 4'hF, 4'd15, 4'h0, 4'h0, 4'h0}, // R2 all low pass
        '{8'h55, 1'b0, 3'd3, 3'd0, 4'hF, 4'h0, 4'd15, 4'h0, 4'h0, 4'h0}, // R1 all high pass
        '{8'h01, 1'b0, 3'd3, 3'd0, 4'h1, 4'hE, 4'd3,  4'h1, 4'hA, 4'h4}, // R3 mid band, expect low
        '{8'h00, 1'b0, 3'd3, 3'd0, 4'h0, 4'hF, 4'd5,  4'hF, 4'h0, 4'h0}, // R5 edge ignores phase 5
        '{8'h00, 1'b1, 3'd2, 3'd4, 4'h0, 4'hF, 4'd5,  4'hF, 4'h0, 4'hF}, // R6 window hit
        '{8'h00, 1'b1, 3'd2, 3'd2, 4'h0, 4'hF, 4'd5,  4'hF, 4'h0, 4'h0}, // R6 just past window
        '{8'h55, 1'b1, 3'd2, 3'd2, 4'hF, 4'h0, 4'd4,  4'hE, 4'h0, 4'h1}, // R6 last window phase
        '{8'hB1, 1'b0, 3'd3, 3'd0, 4'h1, 4'h2, 4'd15, 4'h0, 4'h0, 4'h0}, // R4 masked pins
        '{8'h55, 1'b0, 3'd3, 3'd0, 4'hB, 4'h0, 4'd15, 4'h0, 4'h0, 4'h4}, // R1 R3 mid band, expect high
        '{8'h55, 1'b0, 3'd7, 3'd0, 4'hF, 4'h0, 4'd7,  4'h0, 4'h0, 4'hF}, // R5 strobe on last phase
        '{8'h00, 1'b0, 3'd0, 3'd0, 4'h0, 4'hF, 4'd0,  4'h0, 4'h7, 4'h8}  // R2 R5 strobe on phase 0
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pat_start = 1'b0;
    logic          pat_end = 1'b0;
    logic          win_mode = 1'b0;
    logic [2:0]    strb_pos = '0;
    logic [2:0]    strb_len = '0;
    logic [2*N-1:0] exp_code = '0;
    logic [N-1:0]  above_vh = '0;
    logic [N-1:0]  below_vl = '0;
    logic          busy;
    logic          cyc_done;
    logic [N-1:0]  pin_fail;
    logic          func_fail;
    logic [CW-1:0] first_cyc;
    logic [N-1:0]  first_mask;

    int checks = 0;
    int errors = 0;
    logic saw_done;

    always #5 clk = ~clk;

    strobe_compare #(.N_PINS(N), .PHASES(P), .CYC_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .pat_start(pat_start), .pat_end(pat_end),
        .win_mode(win_mode), .strb_pos(strb_pos), .strb_len(strb_len),
        .exp_code(exp_code), .above_vh(above_vh), .below_vl(below_vl),
        .busy(busy), .cyc_done(cyc_done), .pin_fail(pin_fail),
        .func_fail(func_fail), .first_cyc(first_cyc), .first_mask(first_mask)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drives one full tester cycle, then samples just after the closing edge.
    task automatic run_cycle(input vec_t v);
        for (int ph = 0; ph < P; ph++) begin
            @(negedge clk);
            pat_start = 1'b0;
            exp_code  = v.exp;
            win_mode  = v.win;
            strb_pos  = v.pos;
            strb_len  = v.len;
            if (ph == int'(v.gph)) begin
                above_vh = v.abg;
                below_vl = v.blg;
            end else begin
                above_vh = v.ab;
                below_vl = v.bl;
            end
            @(posedge clk);
        end
        #1;
    endtask

    task automatic start_pattern();
        @(negedge clk);
        pat_start = 1'b1;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R12 busy", busy, 0);
        chk("R12 cyc_done", cyc_done, 0);
        chk("R12 pin_fail", pin_fail, 0);
        chk("R12 func_fail", func_fail, 0);
        chk("R12 first_cyc", first_cyc, 0);
        chk("R12 first_mask", first_mask, 0);
        @(negedge clk);
        rst_n = 1'b1;

        start_pattern();
        chk("R10 busy after start", busy, 1);

        for (int i = 0; i < NV; i++) begin
            run_cycle(TBL[i]);
            chk($sformatf("R7 cyc_done vec %0d", i), cyc_done, 1);
            chk($sformatf("R1/R2/R3/R4/R5/R6 pin_fail vec %0d", i), pin_fail, TBL[i].fail);
        end
        chk("R8 func_fail sticky", func_fail, 1);
        chk("R9 first_cyc", first_cyc, 2);
        chk("R9 first_mask", first_mask, 4'h4);

        // R10: restart clears the record and the cycle index
        start_pattern();
        chk("R10 func_fail cleared", func_fail, 0);
        chk("R10 first_cyc cleared", first_cyc, 0);
        chk("R10 first_mask cleared", first_mask, 0);
        run_cycle(TBL[1]);
        chk("R8 no fail on pass", func_fail, 0);
        run_cycle(TBL[8]);
        chk("R8 fail sets", func_fail, 1);
        chk("R9 first_cyc after restart", first_cyc, 1);
        chk("R9 first_mask after restart", first_mask, 4'h4);

        // R11: abort mid cycle
        for (int ph = 0; ph < 3; ph++) begin
            @(negedge clk);
            exp_code = 8'h55; above_vh = 4'h0; below_vl = 4'h0;
            win_mode = 1'b1; strb_pos = 3'd0; strb_len = 3'd7;
            @(posedge clk);
        end
        @(negedge clk);
        pat_end = 1'b1;
        @(posedge clk);
        #1;
        chk("R11 busy low after end", busy, 0);
        @(negedge clk);
        pat_end = 1'b0;
        saw_done = 1'b0;
        for (int k = 0; k < 2*P; k++) begin
            @(posedge clk);
            #1;
            if (cyc_done) saw_done = 1'b1;
        end
        chk("R11 no cyc_done after abort", saw_done, 0);
        chk("R8 func_fail held through end", func_fail, 1);
        chk("R9 first_cyc held through end", first_cyc, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule